// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives the six gate signals of a three-phase bridge. A triangular carrier is formed by two counters that step together: a lower counter that sweeps from zero up to the period minus the dead time and back down, and an upper counter that always sits the dead-time value above it. Both turn round at the same cycle, at the crest and at the floor of the triangle. Each phase compares one duty value against the pair. The high-side output turns on when the lower counter has reached the duty value. The low-side output is on while the upper counter is still below it. Because the two tests are offset by the dead time, the two outputs of a phase never switch on together, and a gap separates their active periods.

Duty values arrive as plain level inputs that act as buffers. They are copied into the active compare registers only on the cycle the carrier reverses, so a duty change never cuts a pulse short in mid-ramp. While enable is low, the carrier holds, all six outputs are driven inactive, and the compare registers track the duty inputs. This lets software preset the first duty before starting. Period and dead time are control levels that are meant to change only while enable is low. There is no handshake: every input is sampled on each rising clock edge.

Top module: `tri_pwm3`

## Requirements
- R1: After reset all six PWM outputs are low and `count_down` is 0, which means counting up.
- R2: While `enable` is low, the carrier holds its value and direction, and all six outputs are low one cycle later. The compare registers load the duty inputs every cycle.
- R3: While enabled, the lower count climbs by one per cycle up to `top = period - dead`, then falls by one per cycle down to 0, then climbs again. `count_down` is 1 from the cycle after the crest turn until the cycle after the floor turn.
- R4: While enabled, a new duty value is copied into its compare register only on a reversal cycle. A change at any other time has no effect on the outputs until the next reversal.
- R5: The outputs are registered, one cycle behind the counters. `pwm_hi[p]` is 1 when the lower count is at least compare p. `pwm_lo[p]` is 1 when the upper count (lower count plus `dead`) is below compare p. The phase index p is the slice `duty[p*W +: W]`.
- R6: `pwm_hi[p]` and `pwm_lo[p]` are never 1 in the same cycle.
- R7: With a constant duty d where dead <= d <= top, every rising edge of one output of a phase follows at least `dead` cycles in which the other output of that phase was low.
- R8: A duty of 0 holds `pwm_hi` at 1 and `pwm_lo` at 0 for as long as the block is enabled. A duty above `period` holds `pwm_hi` at 0 and `pwm_lo` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Carrier runs and outputs are live while high |
| period | input | W | Crest value of the upper counter |
| dead | input | W | Dead time in cycles, also the offset between the counters |
| duty | input | 3*W | Buffered duty values, phase p in bits p*W +: W |
| pwm_hi | output | 3 | High-side output of each phase |
| pwm_lo | output | 3 | Low-side output of each phase |
| count_down | output | 1 | 1 while the carrier counts downward |

## Verification
A fixed three-phase duty set with a moderate dead time is run for several carrier periods. The gap between the two outputs of each phase is measured at every edge, which separates a correct offset between the counters from one that is missing or has the wrong sign. Duty values of 0 and of period plus one expose clipping faults at the ends of the range. Duty changes made in mid-ramp show whether a reload happens anywhere other than a reversal. Random periods, dead times and duties, with enable pauses between them, are compared every cycle against a reference computed in the bench. These runs tell a turn-round fault at the crest or the floor apart from one in the compare path.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int unsigned DEF_W      = 16;
  localparam int unsigned DEF_PHASES = 3;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/pwm3_carrier.sv
module pwm3_carrier
  import pwm3_pkg::*;
#(
  parameter int unsigned W = DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [W-1:0] period,
  input  logic [W-1:0] dead,
  output logic [W-1:0] cnt_low,
  output logic [W-1:0] cnt_high,
  output logic         turn,
  output dir_e         dir
);
  logic [W-1:0] top;
  logic [W-1:0] low_nx;
  dir_e         dir_nx;

  assign top = period - dead;

  always_comb begin
    low_nx = cnt_low;
    dir_nx = dir;
    turn   = 1'b0;
    if (enable) begin
      if (dir == DIR_UP) begin
        if (cnt_low >= top) begin
          dir_nx = DIR_DOWN;
          turn   = 1'b1;
          low_nx = (cnt_low == '0) ? '0 : cnt_low - 1'b1;
        end else begin
          low_nx = cnt_low + 1'b1;
        end
      end else begin
        if (cnt_low == '0) begin
          dir_nx = DIR_UP;
          turn   = 1'b1;
          low_nx = (top == '0) ? '0 : {{(W-1){1'b0}}, 1'b1};
        end else begin
          low_nx = cnt_low - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_low  <= '0;
      cnt_high <= '0;
      dir      <= DIR_UP;
    end else begin
      cnt_low  <= low_nx;
      cnt_high <= low_nx + dead;
      dir      <= dir_nx;
    end
  end

  // R3: step upward below the crest
  a_r3_climb: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && dir == DIR_UP && cnt_low < top) |=> (cnt_low == $past(cnt_low) + 1'b1));
  // R3: turn at the crest
  a_r3_turn_crest: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && dir == DIR_UP && cnt_low >= top) |=> (dir == DIR_DOWN));
  // R3: turn at the floor
  a_r3_turn_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && dir == DIR_DOWN && cnt_low == '0) |=> (dir == DIR_UP));
  // R2: hold while disabled
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ($stable(cnt_low) && $stable(dir)));
endmodule

// File: rtl/pwm3_cmp_bank.sv
module pwm3_cmp_bank
  import pwm3_pkg::*;
#(
  parameter int unsigned W      = DEF_W,
  parameter int unsigned PHASES = DEF_PHASES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                turn,
  input  logic [PHASES*W-1:0] duty,
  output logic [PHASES*W-1:0] cmp
);
  logic load;
  assign load = !enable || turn;

  for (genvar p = 0; p < PHASES; p++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cmp[p*W +: W] <= '0;
      else if (load) cmp[p*W +: W] <= duty[p*W +: W];
    end
  end

  // R4: no reload between reversals
  a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !turn) |=> $stable(cmp));
  // R2: compares follow the buffers while disabled
  a_r2_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cmp == $past(duty)));
endmodule

// File: rtl/pwm3_phase_out.sv
module pwm3_phase_out
  import pwm3_pkg::*;
#(
  parameter int unsigned W = DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [W-1:0] cnt_low,
  input  logic [W-1:0] cnt_high,
  input  logic [W-1:0] cmp,
  output logic         hi,
  output logic         lo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi <= 1'b0;
      lo <= 1'b0;
    end else begin
      hi <= enable && (cnt_low >= cmp);
      lo <= enable && (cnt_high < cmp);
    end
  end

  // R6: the pair is never active together
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi && lo));
  // R2: outputs inactive after a disabled cycle
  a_r2_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hi && !lo));
endmodule

// File: rtl/tri_pwm3.sv
module tri_pwm3
  import pwm3_pkg::*;
#(
  parameter int unsigned W      = DEF_W,
  parameter int unsigned PHASES = DEF_PHASES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [W-1:0]        period,
  input  logic [W-1:0]        dead,
  input  logic [PHASES*W-1:0] duty,
  output logic [PHASES-1:0]   pwm_hi,
  output logic [PHASES-1:0]   pwm_lo,
  output logic                count_down
);
  logic [W-1:0]        cnt_low;
  logic [W-1:0]        cnt_high;
  logic                turn;
  dir_e                dir;
  logic [PHASES*W-1:0] cmp;

  pwm3_carrier #(.W(W)) u_carrier (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .period   (period),
    .dead     (dead),
    .cnt_low  (cnt_low),
    .cnt_high (cnt_high),
    .turn     (turn),
    .dir      (dir)
  );

  pwm3_cmp_bank #(.W(W), .PHASES(PHASES)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .turn   (turn),
    .duty   (duty),
    .cmp    (cmp)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    pwm3_phase_out #(.W(W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .cnt_low  (cnt_low),
      .cnt_high (cnt_high),
      .cmp      (cmp[p*W +: W]),
      .hi       (pwm_hi[p]),
      .lo       (pwm_lo[p])
    );
  end

  assign count_down = (dir == DIR_DOWN);

  // R1: reset state seen on the ports
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (pwm_hi == '0 && pwm_lo == '0 && !count_down));
endmodule

// File: tb/tri_pwm3_test.sv
module tri_pwm3_test;
  localparam int W = 16;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [W-1:0] period = 16'd40;
  logic [W-1:0] dead = 16'd4;
  logic [W-1:0] d [NP];
  logic [NP*W-1:0] duty;
  logic [NP-1:0] pwm_hi, pwm_lo;
  logic count_down;

  int checks = 0;
  int errors = 0;
  bit chk_on = 0;
  bit gap_on = 0;
  bit r8_on = 0;

  always #4 clk = ~clk;

  assign duty = {d[2], d[1], d[0]};

  tri_pwm3 #(.W(W), .PHASES(NP)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period(period), .dead(dead),
    .duty(duty), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .count_down(count_down)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  logic [W-1:0] m_low, m_high;
  logic m_down;
  logic [W-1:0] m_cmp [NP];
  logic [NP-1:0] e_hi, e_lo;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_low <= '0; m_high <= '0; m_down <= 1'b0;
      e_hi <= '0; e_lo <= '0;
      for (int p = 0; p < NP; p++) m_cmp[p] <= '0;
    end else begin
      logic [W-1:0] top, nlow;
      logic ndown, flip;
      top = period - dead; nlow = m_low; ndown = m_down; flip = 1'b0;
      if (enable) begin
        if (!m_down) begin
          if (m_low >= top) begin ndown = 1'b1; flip = 1'b1; nlow = (m_low == 0) ? 16'd0 : m_low - 16'd1; end
          else nlow = m_low + 16'd1;
        end else begin
          if (m_low == 0) begin ndown = 1'b0; flip = 1'b1; nlow = (top == 0) ? 16'd0 : 16'd1; end
          else nlow = m_low - 16'd1;
        end
      end
      for (int p = 0; p < NP; p++) begin
        e_hi[p] <= enable && (m_low >= m_cmp[p]);
        e_lo[p] <= enable && (m_high < m_cmp[p]);
        if (!enable || flip) m_cmp[p] <= d[p];
      end
      m_low <= nlow; m_high <= nlow + dead; m_down <= ndown;
    end
  end

  int lo_quiet [NP];
  int hi_quiet [NP];
  logic [NP-1:0] prev_hi, prev_lo;

  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      chk(pwm_hi == e_hi, "R5 R4 pwm_hi", int'(pwm_hi), int'(e_hi));
      chk(pwm_lo == e_lo, "R5 R4 pwm_lo", int'(pwm_lo), int'(e_lo));
      chk(count_down == m_down, "R3 direction", int'(count_down), int'(m_down));
      chk((pwm_hi & pwm_lo) == '0, "R6 overlap", int'(pwm_hi & pwm_lo), 0);
      if (!enable)
        chk(pwm_hi == '0 && pwm_lo == '0, "R2 idle outputs", int'({pwm_hi, pwm_lo}), 0);
      if (r8_on) begin
        chk(pwm_hi[0] && !pwm_lo[0], "R8 duty zero", int'({pwm_hi[0], pwm_lo[0]}), 2);
        chk(!pwm_hi[1] && pwm_lo[1], "R8 duty above period", int'({pwm_hi[1], pwm_lo[1]}), 1);
      end
      for (int p = 0; p < NP; p++) begin
        if (gap_on && pwm_hi[p] && !prev_hi[p])
          chk(lo_quiet[p] >= int'(dead), "R7 gap before hi", lo_quiet[p], int'(dead));
        if (gap_on && pwm_lo[p] && !prev_lo[p])
          chk(hi_quiet[p] >= int'(dead), "R7 gap before lo", hi_quiet[p], int'(dead));
        lo_quiet[p] = pwm_lo[p] ? 0 : lo_quiet[p] + 1;
        hi_quiet[p] = pwm_hi[p] ? 0 : hi_quiet[p] + 1;
      end
    end
    prev_hi = pwm_hi;
    prev_lo = pwm_lo;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int p = 0; p < NP; p++) begin d[p] = 16'd0; lo_quiet[p] = 0; hi_quiet[p] = 0; end
    step(3);
    chk(pwm_hi == '0 && pwm_lo == '0, "R1 reset outputs", int'({pwm_hi, pwm_lo}), 0);
    chk(count_down == 1'b0, "R1 reset direction", int'(count_down), 0);
    rst_n = 1'b1;
    step(1);
    chk_on = 1;
    chk(pwm_hi == '0 && pwm_lo == '0 && !count_down, "R1 after release",
        int'({pwm_hi, pwm_lo, count_down}), 0);

    // R2: idle with duties preset
    d[0] = 16'd10; d[1] = 16'd20; d[2] = 16'd30;
    step(5);

    // R7: steady duties, gap measured
    enable = 1'b1;
    step(100);
    gap_on = 1;
    step(320);
    gap_on = 0;

    // R4: mid-ramp duty changes
    d[0] = 16'd30; d[2] = 16'd6;
    step(13);
    d[1] = 16'd5;
    step(90);

    // R2: pause in mid-ramp then resume
    enable = 1'b0;
    step(7);
    enable = 1'b1;
    step(60);

    // R8: end-of-range duties
    enable = 1'b0;
    d[0] = 16'd0; d[1] = 16'd41; d[2] = 16'd15;
    step(2);
    enable = 1'b1;
    step(2);
    r8_on = 1;
    step(300);
    r8_on = 0;

    // random rounds
    for (int r = 0; r < 24; r++) begin
      enable = 1'b0;
      step(2);
      period = 16'($urandom_range(8, 70));
      dead = 16'($urandom_range(0, int'(period) / 3));
      for (int p = 0; p < NP; p++) d[p] = 16'($urandom_range(0, int'(period) + 1));
      step(2);
      enable = 1'b1;
      for (int k = 0; k < 6; k++) begin
        step($urandom_range(10, 80));
        d[$urandom_range(0, NP - 1)] = 16'($urandom_range(0, int'(period) + 1));
      end
    end
    enable = 1'b0;
    step(3);
    finish_run();
  end
endmodule